// File: doc/BRIEF.md
# Replicated-Copy Multi-Read Register-File RAM

A small, shallow memory of the kind built from lookup-table cells. It has one write port, synchronous to the clock, and a configurable number of read ports. Each read port owns a full copy of the storage, so a port never waits for another port. Every copy sees the same write enable, address and data on each clock edge, so all copies hold the same contents, while each copy is read at its own address. Each copy is assembled from 16-entry cells. Upper address bits pick the cell that is written and the cell that is read.

Each read port is combinational by default. A per-port parameter bit puts a register behind a port, which turns it into a synchronous read with one cycle of latency. A second parameter ties port 0's read address to the write address. Port 0 then acts as a read/write port and the remaining ports are read-only. The synchronous active-high reset clears only the output registers. It does not touch the stored words, and it does not block writes.

Top module: `mrp_dram`

## Requirements
- R1: When `wr_en` is high at a rising clock edge, `wr_data` is stored at `wr_addr`. A read of that address after the edge returns the new word.
- R2: When `wr_en` is low at an edge, no stored word changes, whatever `wr_addr` and `wr_data` carry.
- R3: An asynchronous read port shows the word at its current address within the same cycle, with no clock edge between the address change and the data.
- R4: An asynchronous read of the address being written in the same cycle returns the old word until the edge and the new word after it.
- R5: A registered read port presents, in the cycle after an edge, the word its address selected just before that edge. If the same edge also wrote that address, the port presents the old word.
- R6: While `rst` is high at an edge, every registered read output becomes zero. Stored words survive reset, and writes made during reset take effect.
- R7: Port k's address is `rd_addr[k*AW +: AW]` and its data is `rd_data[k*WIDTH +: WIDTH]`. The ports read independently, and ports that share an address return the same word.
- R8: With `PORT0_RW` = 1, port 0 reads at `wr_addr`, and the slot `rd_addr[AW-1:0]` has no effect.
- R9: `DEPTH` is 16, 32 or 64, and `AW` = log2(`DEPTH`). The lowest and highest addresses of every 16-entry cell, up to `DEPTH`-1, store and read back correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and output registers act on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the registered read outputs |
| wr_en | input | 1 | Write enable |
| wr_addr | input | AW | Write address (also port 0's read address when `PORT0_RW` = 1) |
| wr_data | input | WIDTH | Word to store |
| rd_addr | input | NUM_RD*AW | Packed read addresses, port k at bits k*AW upward |
| rd_data | output | NUM_RD*WIDTH | Packed read data, port k at bits k*WIDTH upward |

## Verification
The assertions check the following on every cycle:
- an enabled write lands in its cell;
- an idle write port leaves a copy's output unchanged at a steady address;
- each registered output follows its input by one cycle and is zero after reset;
- copies read at the same address agree.

Only the bench scenarios can show three further behaviours: old-then-new data on a same-address write, data that depends on the exact address mapping of each packed port, and contents that survive a mid-run reset. The bench shows these by comparing every port against a reference array under random traffic and directed corner cases.

// File: rtl/mrp_dram_pkg.sv
package mrp_dram_pkg;

    localparam int unsigned CELL_DEPTH = 16;
    localparam int unsigned CELL_AW    = 4;

    typedef enum logic {
        RD_COMB = 1'b0,
        RD_REGD = 1'b1
    } rd_kind_e;

    function automatic int unsigned addr_bits(input int unsigned depth);
        return $clog2(depth);
    endfunction

    function automatic bit depth_legal(input int unsigned depth);
        return (depth == 16) || (depth == 32) || (depth == 64);
    endfunction

    function automatic int unsigned cell_count(input int unsigned depth);
        return depth / CELL_DEPTH;
    endfunction

    function automatic rd_kind_e kind_of(input logic sel);
        return sel ? RD_REGD : RD_COMB;
    endfunction

endpackage

// File: rtl/mrp_dram_slice.sv
module mrp_dram_slice #(
    parameter int WIDTH = 8
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  we,
    input  logic [mrp_dram_pkg::CELL_AW-1:0]      waddr,
    input  logic [WIDTH-1:0]                      wdata,
    input  logic [mrp_dram_pkg::CELL_AW-1:0]      raddr,
    output logic [WIDTH-1:0]                      rdata
);
    import mrp_dram_pkg::*;

    logic [WIDTH-1:0] cells [CELL_DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

    // R1: an enabled write is found in its cell one edge later
    a_r1_write_lands: assert property (@(posedge clk) disable iff (rst)
        we |=> cells[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/mrp_dram_bank.sv
module mrp_dram_bank #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 8,
    localparam int AW   = mrp_dram_pkg::addr_bits(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);
    import mrp_dram_pkg::*;

    localparam int NCELL = cell_count(DEPTH);
    localparam int SW    = (AW > CELL_AW) ? AW - CELL_AW : 1;

    logic [WIDTH-1:0] cell_rd [NCELL];
    logic [AW-1:0]    wr_hi_full;
    logic [AW-1:0]    rd_hi_full;
    logic [SW-1:0]    wr_sel;
    logic [SW-1:0]    rd_sel;

    assign wr_hi_full = wr_addr >> CELL_AW;
    assign rd_hi_full = rd_addr >> CELL_AW;
    assign wr_sel     = wr_hi_full[SW-1:0];
    assign rd_sel     = rd_hi_full[SW-1:0];

    for (genvar c = 0; c < NCELL; c++) begin : g_cell
        logic cell_we;
        assign cell_we = wr_en && (wr_sel == SW'(c));

        mrp_dram_slice #(.WIDTH(WIDTH)) u_slice (
            .clk   (clk),
            .rst   (rst),
            .we    (cell_we),
            .waddr (wr_addr[CELL_AW-1:0]),
            .wdata (wr_data),
            .raddr (rd_addr[CELL_AW-1:0]),
            .rdata (cell_rd[c])
        );
    end

    if (NCELL == 1) begin : g_single
        assign rd_data = cell_rd[0];
    end else begin : g_mux
        always_comb begin
            rd_data = '0;
            for (int c = 0; c < NCELL; c++) begin
                if (rd_sel == SW'(c)) begin
                    rd_data = cell_rd[c];
                end
            end
        end
    end

    // R2: with the write port idle, a steady address keeps a steady word
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(rd_addr) -> $stable(rd_data)));

endmodule

// File: rtl/mrp_dram_rd_stage.sv
module mrp_dram_rd_stage #(
    parameter int WIDTH                  = 8,
    parameter mrp_dram_pkg::rd_kind_e KIND = mrp_dram_pkg::RD_COMB
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    import mrp_dram_pkg::*;

    if (KIND == RD_REGD) begin : g_reg
        logic [WIDTH-1:0] q_r;

        always_ff @(posedge clk) begin
            if (rst) begin
                q_r <= '0;
            end else begin
                q_r <= d;
            end
        end

        assign q = q_r;

        // R5: registered port shows the value selected before the edge
        a_r5_reg_follows: assert property (@(posedge clk) disable iff (rst)
            !rst |=> q == $past(d));

        // R6: reset drives the registered output to zero
        a_r6_reset_zero: assert property (@(posedge clk)
            rst |=> q == '0);
    end else begin : g_comb
        assign q = d;
    end

endmodule

// File: rtl/mrp_dram.sv
module mrp_dram #(
    parameter int           DEPTH    = 32,
    parameter int           WIDTH    = 8,
    parameter int           NUM_RD   = 3,
    parameter logic [NUM_RD-1:0] RD_REG = 3'b010,
    parameter bit           PORT0_RW = 1'b1,
    localparam int          AW       = mrp_dram_pkg::addr_bits(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [WIDTH-1:0]        wr_data,
    input  logic [NUM_RD*AW-1:0]    rd_addr,
    output logic [NUM_RD*WIDTH-1:0] rd_data
);
    import mrp_dram_pkg::*;

    typedef struct packed {
        logic             en;
        logic [AW-1:0]    addr;
        logic [WIDTH-1:0] data;
    } wr_req_t;

    if (!depth_legal(DEPTH)) begin : g_bad_depth
        $error("mrp_dram: DEPTH must be 16, 32 or 64");
    end

    wr_req_t          wreq;
    logic [AW-1:0]    port_addr [NUM_RD];
    logic [WIDTH-1:0] raw_rd    [NUM_RD];

    assign wreq = '{en: wr_en, addr: wr_addr, data: wr_data};

    for (genvar k = 0; k < NUM_RD; k++) begin : g_port
        if (PORT0_RW && k == 0) begin : g_rw
            assign port_addr[k] = wreq.addr;
        end else begin : g_ro
            assign port_addr[k] = rd_addr[k*AW +: AW];
        end

        mrp_dram_bank #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wreq.en),
            .wr_addr (wreq.addr),
            .wr_data (wreq.data),
            .rd_addr (port_addr[k]),
            .rd_data (raw_rd[k])
        );

        mrp_dram_rd_stage #(.WIDTH(WIDTH), .KIND(kind_of(RD_REG[k]))) u_stage (
            .clk (clk),
            .rst (rst),
            .d   (raw_rd[k]),
            .q   (rd_data[k*WIDTH +: WIDTH])
        );

        if (k > 0) begin : g_agree
            // R7: copies read at a shared address hold the same word
            a_r7_copies_agree: assert property (@(posedge clk) disable iff (rst)
                (port_addr[k] == port_addr[0]) |-> (raw_rd[k] == raw_rd[0]));
        end
    end

endmodule

// File: tb/mrp_dram_tb.sv
module mrp_dram_tb;
    localparam int DEPTH = 32;
    localparam int WIDTH = 8;
    localparam int NRD   = 3;
    localparam int AW    = 5;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  wr_en = 1'b0;
    logic [AW-1:0]         wr_addr = '0;
    logic [WIDTH-1:0]      wr_data = '0;
    logic [NRD*AW-1:0]     rd_addr = '0;
    logic [NRD*WIDTH-1:0]  rd_data;

    int tests = 0;
    int fails = 0;

    logic [WIDTH-1:0] ref_m [DEPTH];
    bit               vld   [DEPTH];
    logic [WIDTH-1:0] pend;
    bit               pend_v = 1'b0;
    string            pend_tag = "R5";

    always #10 clk = ~clk;

    mrp_dram #(.DEPTH(DEPTH), .WIDTH(WIDTH), .NUM_RD(NRD),
               .RD_REG(3'b010), .PORT0_RW(1'b1)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data));

    function automatic logic [WIDTH-1:0] expect_word(input logic [AW-1:0] a);
        return ref_m[a];
    endfunction

    task automatic chk(input logic [WIDTH-1:0] got, input logic [WIDTH-1:0] exp, input string req);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // port 0 reads at wr_addr (R8), port 1 registered (R5), port 2 combinational (R3)
    task automatic step(input bit r, input bit we, input logic [AW-1:0] wa,
                        input logic [WIDTH-1:0] wd, input logic [AW-1:0] a0,
                        input logic [AW-1:0] a1, input logic [AW-1:0] a2,
                        input string tag);
        @(negedge clk);
        if (pend_v) chk(rd_data[WIDTH +: WIDTH], pend, pend_tag);
        rst = r; wr_en = we; wr_addr = wa; wr_data = wd;
        rd_addr = {a2, a1, a0};
        #2;
        if (vld[wa]) chk(rd_data[0 +: WIDTH], expect_word(wa), {tag, " R8 port0"});
        if (vld[a2]) chk(rd_data[2*WIDTH +: WIDTH], expect_word(a2), {tag, " port2"});
        pend     = r ? '0 : expect_word(a1);
        pend_v   = r || vld[a1];
        pend_tag = r ? "R6 reg clear" : "R5 reg port";
        @(posedge clk);
        if (we) begin
            ref_m[wa] = wd;
            vld[wa]   = 1'b1;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < DEPTH; i++) vld[i] = 1'b0;
        step(1, 0, 0, 0, 0, 0, 0, "R6");
        // R6: fill during reset; writes still take effect, reg port held at 0
        for (int i = 0; i < DEPTH; i++)
            step(1, 1, AW'(i), WIDTH'($urandom), 0, 0, 0, "R6");
        // R9: cell boundaries read back; R1 writes landed
        step(0, 0, 0,  0, 0, 5'd0,  5'd31, "R9");
        step(0, 0, 15, 0, 0, 5'd15, 5'd16, "R9");
        step(0, 0, 16, 0, 0, 5'd31, 5'd0,  "R1");
        // R4: write 5 then rewrite while reading it asynchronously
        step(0, 1, 5, 8'hA5, 0, 5, 5, "R4");
        step(0, 1, 5, 8'h3C, 0, 5, 5, "R4");
        step(0, 0, 5, 8'h00, 0, 5, 5, "R4");
        // R2: idle write port with garbage
        step(0, 0, 7, 8'hFF, 0, 7, 7, "R2");
        step(0, 0, 7, 8'h11, 0, 7, 7, "R2");
        // R8: rd_addr slot 0 ignored, port 0 follows wr_addr
        step(0, 0, 9, 0, 5'd3,  9, 9, "R8");
        step(0, 0, 9, 0, 5'd30, 9, 9, "R8");
        // R7: all ports at one address, then all different
        step(0, 1, 12, 8'h5A, 12, 12, 12, "R7");
        step(0, 0, 12, 0, 1, 12, 12, "R7");
        step(0, 0, 2, 0, 4, 20, 28, "R7");
        // R6: mid-run reset keeps contents
        step(1, 0, 3, 0, 0, 3, 3, "R6");
        step(0, 0, 3, 0, 0, 3, 3, "R6");
        step(0, 0, 3, 0, 0, 3, 3, "R6");
        // R3/R5 random traffic
        for (int n = 0; n < 3000; n++)
            step(0, 1'($urandom), AW'($urandom), WIDTH'($urandom),
                 AW'($urandom), AW'($urandom), AW'($urandom), "R3");
        step(0, 0, 0, 0, 0, 0, 0, "R5");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule